// File: doc/BRIEF.md
# Constant On-Time Switching Sequencer

This block is the digital control core of a hysteretic step-down converter that runs without a free-running oscillator. Three single-bit comparator flags come in: feedback below reference, current limit active, and inductor current at zero. The block also takes a mode select for skip or forced-continuous operation and an on-time count. From these it drives a high-side and a low-side switch request. Gate dead-time and fault supervision are handled elsewhere.

A switching pulse begins only when three conditions hold together: feedback is low, the current limit is clear and the minimum off-time has elapsed. Each pulse is a latched one-shot. Its length is the requested on-time, raised to a floor and extended by a fixed delay, and it is captured when the pulse starts. After the pulse, a blanking counter enforces the minimum off-time.

The control is a four-state machine. DISABLED leaves both requests low. ON asserts the high side. LS_HOLD asserts the low side. IDLE leaves both requests low while the block waits in skip mode. The transitions are: ENABLE (DISABLED to LS_HOLD), FIRE (LS_HOLD or IDLE to ON), EXPIRE (ON to LS_HOLD when the one-shot ends) and RELEASE (LS_HOLD to IDLE when, in skip mode, the zero-crossing flag is seen). Dropping the enable takes any state back to DISABLED on the next edge.

Top module: `cot_seq`

## Requirements
- R1: While reset is held or enable is low, hs_on and ls_on are both 0 one edge later, and all internal counters are cleared.
- R2: On the first edge at which enable is seen high, the block enters LS_HOLD: ls_on is 1 and hs_on is 0.
- R3: hs_on rises on the edge after a cycle in which fb_low is 1, ilim is 0 and the minimum off-time has elapsed, all three together.
- R4: While ilim is 1, no new pulse starts.
- R5: A pulse keeps hs_on high for exactly max(ton_req, TON_MIN) + TDLY cycles. The ton_req value used is the one sampled at the FIRE edge, so later changes have no effect on a pulse already running.
- R6: Toggling fb_low during a pulse neither shortens it nor starts a new pulse.
- R7: On the edge where a pulse ends, hs_on goes to 0 and ls_on goes to 1 together.
- R8: After a pulse ends, hs_on stays low for at least TOFF cycles. It stays low for exactly TOFF cycles when the start conditions hold throughout.
- R9: With skip_mode at 0, ls_on stays 1 until the next pulse, whatever zc does.
- R10: With skip_mode at 1, ls_on drops on the edge after a cycle in LS_HOLD in which zc is 1. ls_on then stays 0 until the next pulse.
- R11: hs_on and ls_on are never both 1.
- R12: Dropping enable in the middle of a pulse clears both requests on the next edge. When enable returns, the block restarts through LS_HOLD with the off-time already elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable |
| fb_low | input | 1 | Feedback is below the reference |
| ilim | input | 1 | Valley current limit is active |
| zc | input | 1 | Inductor current has reached zero |
| skip_mode | input | 1 | 1 = pulse skipping, 0 = forced continuous |
| ton_req | input | TW (10) | Requested on-time in clock cycles |
| hs_on | output | 1 | High-side switch request |
| ls_on | output | 1 | Low-side switch request |

## Verification
The assertions assume the comparator flags are synchronous to clk and hold steady between edges. They also assume TOFF is at least 1 and TON_MIN + TDLY is at least 1, which makes every pulse at least one cycle long. The stimulus meets these conditions by changing every input just after a rising edge and using the default parameters. A random phase varies enable rarely, current limit and zero crossing at moderate rates, and ton_req on both sides of the floor, so all four states and every transition are visited. Directed sequences cover the clamp, the latching of ton_req, comparator chatter during a pulse, the release in skip mode and an abort in the middle of a pulse.

// File: rtl/cot_pkg.sv
package cot_pkg;
    typedef enum logic [1:0] {
        ST_DIS  = 2'd0,
        ST_ON   = 2'd1,
        ST_LSON = 2'd2,
        ST_IDLE = 2'd3
    } cot_state_e;
endpackage

// File: rtl/cot_ontime.sv
// Applies the on-time floor and adds the fixed propagation allowance.
module cot_ontime #(
    parameter int TW      = 10,
    parameter int TON_MIN = 6,
    parameter int TDLY    = 2
) (
    input  logic [TW-1:0] ton_req,
    output logic [TW:0]   ton_eff
);
    localparam logic [TW-1:0] FLOOR = TW'(TON_MIN);
    localparam logic [TW:0]   DLY   = (TW+1)'(TDLY);

    logic [TW-1:0] clamped;

    always_comb begin
        clamped = (ton_req < FLOOR) ? FLOOR : ton_req;
        ton_eff = {1'b0, clamped} + DLY;
    end
endmodule

// File: rtl/cot_downcnt.sv
// Loadable saturating down-counter used for the one-shot and the blanking window.
module cot_downcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         zero
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/cot_seq.sv
module cot_seq #(
    parameter int TW      = 10,
    parameter int TON_MIN = 6,
    parameter int TDLY    = 2,
    parameter int TOFF    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          fb_low,
    input  logic          ilim,
    input  logic          zc,
    input  logic          skip_mode,
    input  logic [TW-1:0] ton_req,
    output logic          hs_on,
    output logic          ls_on
);
    import cot_pkg::*;

    localparam int CW   = TW + 1;
    localparam int OFFW = (TOFF > 2) ? $clog2(TOFF) : 1;
    localparam logic [OFFW-1:0] OFF_LOAD = OFFW'(TOFF - 1);

    cot_state_e    state, nxt;
    logic [CW-1:0] ton_eff;
    logic [CW-1:0] on_cnt;
    logic [OFFW-1:0] off_cnt;
    logic          on_zero, off_zero;
    logic          waiting, fire, on_last;

    cot_ontime #(.TW(TW), .TON_MIN(TON_MIN), .TDLY(TDLY)) u_ontime (
        .ton_req (ton_req),
        .ton_eff (ton_eff)
    );

    assign waiting = (state == ST_LSON) || (state == ST_IDLE);
    assign fire    = en && waiting && fb_low && !ilim && off_zero;
    assign on_last = en && (state == ST_ON) && (on_cnt == CW'(1));

    cot_downcnt #(.W(CW)) u_oneshot (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!en),
        .load     (fire),
        .load_val (ton_eff),
        .dec      (state == ST_ON),
        .cnt      (on_cnt),
        .zero     (on_zero)
    );

    cot_downcnt #(.W(OFFW)) u_blank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!en),
        .load     (on_last),
        .load_val (OFF_LOAD),
        .dec      (1'b1),
        .cnt      (off_cnt),
        .zero     (off_zero)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        if (!en) begin
            nxt = ST_DIS;
        end else begin
            unique case (state)
                ST_DIS:  nxt = ST_LSON;
                ST_ON:   if (on_last) nxt = ST_LSON;
                ST_LSON: begin
                    if (fire)                 nxt = ST_ON;
                    else if (skip_mode && zc) nxt = ST_IDLE;
                end
                ST_IDLE: if (fire) nxt = ST_ON;
                default: nxt = ST_DIS;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_DIS;
        else        state <= nxt;
    end

    // output decode
    always_comb begin
        hs_on = 1'b0;
        ls_on = 1'b0;
        unique case (state)
            ST_ON:   hs_on = 1'b1;
            ST_LSON: ls_on = 1'b1;
            default: ;
        endcase
    end

    // R11: requests mutually exclusive
    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on && ls_on));

    // R3: a rising high-side request needs all start conditions in the prior cycle
    p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_on) |-> $past(en && fb_low && !ilim));

    // R8: no pulse may run while the blanking window is still counting
    p_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ON) |-> off_zero);

    // R1: disable clears both requests on the next edge
    p_dis_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!hs_on && !ls_on));

    // R7: pulse end hands over to the low side
    p_handover_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_on && en && on_cnt == CW'(1)) |=> (ls_on && !hs_on));

    // R9: forced-continuous holds low side until the next pulse
    p_fcm_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_on && en && !skip_mode) |=> (ls_on || hs_on));

    // R5: the one-shot never runs empty while a pulse is active
    p_oneshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hs_on |-> !on_zero);
endmodule

// File: tb/sim_cot_seq.sv
module sim_cot_seq;
    localparam int TW      = 10;
    localparam int TON_MIN = 6;
    localparam int TDLY    = 2;
    localparam int TOFF    = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, fb_low = 1'b0, ilim = 1'b0, zc = 1'b0, skip_mode = 1'b0;
    logic [TW-1:0] ton_req = '0;
    logic hs_on, ls_on;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model state: 0 disabled, 1 on, 2 low-side held, 3 idle
    int m_st = 0;
    int m_on = 0;
    int m_off = 0;

    always #2 clk = ~clk;

    cot_seq #(.TW(TW), .TON_MIN(TON_MIN), .TDLY(TDLY), .TOFF(TOFF)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .fb_low(fb_low), .ilim(ilim),
        .zc(zc), .skip_mode(skip_mode), .ton_req(ton_req),
        .hs_on(hs_on), .ls_on(ls_on)
    );

    function automatic int eff_ton(input int req);
        return ((req < TON_MIN) ? TON_MIN : req) + TDLY;
    endfunction

    function automatic bit exp_hs();
        return m_st == 1;
    endfunction

    function automatic bit exp_ls();
        return m_st == 2;
    endfunction

    task automatic model_tick();
        bit go;
        if (!rst_n || !en) begin
            m_st = 0; m_on = 0; m_off = 0;
        end else begin
            case (m_st)
                0: m_st = 2;
                1: begin
                    if (m_on == 1) begin m_st = 2; m_off = TOFF - 1; m_on = 0; end
                    else m_on = m_on - 1;
                end
                default: begin
                    go = fb_low && !ilim && (m_off == 0);
                    if (m_off > 0) m_off = m_off - 1;
                    if (go) begin m_st = 1; m_on = eff_ton(int'(ton_req)); end
                    else if (m_st == 2 && skip_mode && zc) m_st = 3;
                end
            endcase
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_tick();
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic meas_high(input bit chatter, output int w);
        w = 0;
        while (hs_on && w < 2000) begin
            w++;
            if (chatter) fb_low = ~fb_low;
            step();
        end
    endtask

    task automatic meas_low(output int g);
        g = 0;
        while (!hs_on && g < 2000) begin
            g++;
            step();
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        int w, g;
        void'($urandom(32'h00C0_7E11));
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: reset / disabled state
        chk("R1 hs", hs_on, 0);
        chk("R1 ls", ls_on, 0);

        // R2: enable enters low-side hold
        en = 1'b1; fb_low = 1'b0;
        step();
        chk("R2 hs", hs_on, 0);
        chk("R2 ls", ls_on, 1);

        // R4: current limit inhibits starts
        fb_low = 1'b1; ilim = 1'b1;
        for (int i = 0; i < 5; i++) begin
            step();
            chk("R4 hs", hs_on, 0);
        end

        // R3: all three conditions -> fire next edge
        ilim = 1'b0; ton_req = 10'd3;
        step();
        chk("R3 hs", hs_on, 1);

        // R6 and clamp part of R5: chatter on feedback during a floored pulse
        meas_high(1'b1, w);
        chk("R6 width", w, eff_ton(3));
        chk("R7 hs", hs_on, 0);
        chk("R7 ls", ls_on, 1);

        // R8: off-time with start conditions held
        fb_low = 1'b1; ton_req = 10'd20;
        meas_low(g);
        chk("R8 gap", g, TOFF);

        // R5: ton_req captured at fire; change mid pulse ignored
        ton_req = 10'd7;
        meas_high(1'b0, w);
        chk("R5 width", w, eff_ton(20));

        // R9: forced mode keeps low side through zero crossings
        fb_low = 1'b0; zc = 1'b1; skip_mode = 1'b0;
        for (int i = 0; i < 10; i++) begin
            step();
            chk("R9 ls", ls_on, 1);
        end
        zc = 1'b0;

        // R10: skip mode releases low side on zero crossing
        skip_mode = 1'b1; fb_low = 1'b1;
        meas_low(g);
        fb_low = 1'b0; zc = 1'b1;
        meas_high(1'b0, w);
        chk("R10 ls_after_pulse", ls_on, 1);
        step();
        chk("R10 ls_released", ls_on, 0);
        zc = 1'b0;
        step();
        chk("R10 ls_stays_off", ls_on, 0);
        chk("R10 hs", hs_on, 0);

        // R12: abort mid pulse, restart with off-time elapsed
        fb_low = 1'b1;
        meas_low(g);
        step();
        en = 1'b0;
        step();
        chk("R12 hs_abort", hs_on, 0);
        chk("R12 ls_abort", ls_on, 0);
        en = 1'b1;
        step();
        chk("R12 ls_restart", ls_on, 1);
        step();
        chk("R12 hs_refire", hs_on, 1);

        // random phase against the reference model
        for (int i = 0; i < 6000; i++) begin
            en        = ($urandom % 200) != 0;
            fb_low    = ($urandom % 2) == 1;
            ilim      = ($urandom % 7) == 0;
            zc        = ($urandom % 5) == 0;
            if (($urandom % 60) == 0) skip_mode = ~skip_mode;
            if (($urandom % 4) == 0) ton_req = TW'($urandom % 24);
            step();
            chk("R3 rand hs", hs_on, exp_hs());
            chk("R10 rand ls", ls_on, exp_ls());
            chk("R11 excl", hs_on & ls_on, 0);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule